// File: doc/BRIEF.md
# PCIe Slot Fundamental-Reset Sequencer

This block drives the fundamental-reset line of one PCIe add-in card slot from a single system clock. After a start request it switches on the slot supply and waits for the power-good indication to stay high for a supply-settling window. It then turns on the reference clock and waits for a clock-settling window. Only after both windows, and after the reset line has been held low for its minimum assertion time, does it drive the active-low reset high. One cycle after that, it reports that the link may begin training.

The three windows are parameters given in clock cycles, so a system clock of any rate can meet the real minimums. A testbench can also shorten them. The supply-settling wait can be skipped when a parameter allows it and the `supply_own_i` input says the supply was brought up outside this block. If power-good drops after the reference clock is on, a combinational path pulls reset low in the same cycle, without waiting for the state register. The block then holds reset until power is back and the minimum assertion time has elapsed, and restarts from the supply wait.

Top module: `pcie_slot_rst_seq`

## Requirements
- R1: Out of reset, `slot_pwr_en_o`, `refclk_en_o`, `perst_n_o` and `link_rdy_o` are all 0, and they stay 0 until `start_i` is sampled high.
- R2: When `supply_own_i`=1 or `SKIP_PWR_WAIT`=0, `refclk_en_o` rises exactly `PWR_STABLE_CYC`+1 cycles after `slot_pwr_en_o` rises, provided `pwr_good_i` is high throughout. Only consecutive cycles of high power-good count, and a single low cycle restarts the window.
- R3: When `SKIP_PWR_WAIT`=1 and `supply_own_i`=0, `refclk_en_o` rises one cycle after the supply wait is entered, provided `pwr_good_i` is high.
- R4: `perst_n_o` rises exactly `CLK_STABLE_CYC`+1 cycles after `refclk_en_o` rises, unless the minimum assertion time (R5) ends later. It never rises earlier than that.
- R5: Every low period of `perst_n_o` lasts at least `MIN_ASSERT_CYC` clock cycles.
- R6: While the reference clock is enabled, a falling `pwr_good_i` forces `perst_n_o` low in the same cycle, through combinational logic. `refclk_en_o` drops on the next clock edge and `slot_pwr_en_o` stays high.
- R7: After such a power fault, `refclk_en_o` and `perst_n_o` stay low as long as `pwr_good_i` is low. The sequence restarts with the supply wait of R2/R3 only after power-good has returned and the minimum assertion time has passed.
- R8: `link_rdy_o` rises one cycle after `perst_n_o` rises, and it falls in the same cycle that `perst_n_o` falls.
- R9: `start_i` has no effect once the sequence has left the idle state. In particular, a pulse while reset is released leaves all outputs unchanged.
- R10: `perst_n_o` is high only while both `refclk_en_o` and `slot_pwr_en_o` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| start_i | input | 1 | Begin the power-up sequence (sampled only when idle) |
| pwr_good_i | input | 1 | Slot supply valid indication |
| supply_own_i | input | 1 | 1 = this block switched the supply on, so the supply-settling wait is mandatory |
| slot_pwr_en_o | output | 1 | Slot supply enable |
| refclk_en_o | output | 1 | Reference clock enable toward the PHY |
| perst_n_o | output | 1 | Active-low fundamental reset to the card |
| link_rdy_o | output | 1 | Reset released; link training may start |

## Verification
Two functions of this block can fall in the same cycle. The first is a power-fault response, which drops reset combinationally and moves the state to fault. The second is a pending release, where the clock window and minimum assertion expire together, or a start pulse arrives while reset is released. The bench provokes these by dropping power-good at random moments after release, with start pulses placed at random inside the fault hold. It judges that reset and link-ready fall in the very cycle power-good falls, that the reference clock stays off for the whole hold, and that the restart delay is no shorter than the supply window plus the clock window. Directed runs separately pin the exact cycle counts of each window and the case where the minimum assertion time, rather than the clock window, sets the release cycle.

// File: rtl/pcie_slot_rst_pkg.sv
package pcie_slot_rst_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE    = 3'd0,
    SEQ_SUPPLY  = 3'd1,
    SEQ_REFCLK  = 3'd2,
    SEQ_UP      = 3'd3,
    SEQ_FAULT   = 3'd4
  } seq_state_e;
endpackage

// File: rtl/seq_sat_cnt.sv
// Saturating window counter: counts enabled cycles up to LIMIT and holds.
module seq_sat_cnt #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic done
);
  localparam int W = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr)        cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + W'(1);
  end

  assign done = (cnt_q == LIM);
endmodule

// File: rtl/seq_ctrl_fsm.sv
// Sequencing state machine; all timing comes from the window counters.
module seq_ctrl_fsm
  import pcie_slot_rst_pkg::*;
#(
  parameter bit SKIP_PWR_WAIT = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       pwr_good_i,
  input  logic       supply_own_i,
  input  logic       pwr_win_done,
  input  logic       clk_win_done,
  input  logic       min_win_done,
  output seq_state_e state_q
);
  seq_state_e state_d;
  logic       skip_ok;

  assign skip_ok = SKIP_PWR_WAIT && !supply_own_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:   if (start_i) state_d = SEQ_SUPPLY;
      SEQ_SUPPLY: if (pwr_good_i && (skip_ok || pwr_win_done)) state_d = SEQ_REFCLK;
      SEQ_REFCLK: begin
        if (!pwr_good_i)                       state_d = SEQ_FAULT;
        else if (clk_win_done && min_win_done) state_d = SEQ_UP;
      end
      SEQ_UP:     if (!pwr_good_i) state_d = SEQ_FAULT;
      SEQ_FAULT:  if (pwr_good_i && min_win_done) state_d = SEQ_SUPPLY;
      default:    state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/pcie_slot_rst_seq.sv
// Top: slot supply, reference clock and fundamental-reset sequencing.
module pcie_slot_rst_seq
  import pcie_slot_rst_pkg::*;
#(
  parameter int PWR_STABLE_CYC = 10_000_000,
  parameter int CLK_STABLE_CYC = 10_000,
  parameter int MIN_ASSERT_CYC = 10_000,
  parameter bit SKIP_PWR_WAIT  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic pwr_good_i,
  input  logic supply_own_i,
  output logic slot_pwr_en_o,
  output logic refclk_en_o,
  output logic perst_n_o,
  output logic link_rdy_o
);
  seq_state_e state_q;
  logic       pwr_win_done, clk_win_done, min_win_done;
  logic       link_q;

  // Supply window: only uninterrupted power-good cycles inside the supply wait count.
  seq_sat_cnt #(.LIMIT(PWR_STABLE_CYC)) u_pwr_win (
    .clk(clk), .rst_n(rst_n),
    .clr((state_q != SEQ_SUPPLY) || !pwr_good_i),
    .done(pwr_win_done)
  );

  // Clock window: cycles since the reference clock was enabled.
  seq_sat_cnt #(.LIMIT(CLK_STABLE_CYC)) u_clk_win (
    .clk(clk), .rst_n(rst_n),
    .clr(state_q != SEQ_REFCLK),
    .done(clk_win_done)
  );

  // Assertion window: cycles the reset line has been held low.
  seq_sat_cnt #(.LIMIT(MIN_ASSERT_CYC)) u_min_win (
    .clk(clk), .rst_n(rst_n),
    .clr(perst_n_o),
    .done(min_win_done)
  );

  seq_ctrl_fsm #(.SKIP_PWR_WAIT(SKIP_PWR_WAIT)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .start_i(start_i), .pwr_good_i(pwr_good_i), .supply_own_i(supply_own_i),
    .pwr_win_done(pwr_win_done), .clk_win_done(clk_win_done),
    .min_win_done(min_win_done),
    .state_q(state_q)
  );

  assign slot_pwr_en_o = (state_q != SEQ_IDLE);
  assign refclk_en_o   = (state_q == SEQ_REFCLK) || (state_q == SEQ_UP);
  // Fast path: power-good gates reset without passing through a register.
  assign perst_n_o     = (state_q == SEQ_UP) && pwr_good_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) link_q <= 1'b0;
    else        link_q <= perst_n_o;
  end

  assign link_rdy_o = link_q && perst_n_o;
endmodule

// File: rtl/pcie_slot_rst_seq_chk.sv
// Property checker attached to the sequencer top.
module pcie_slot_rst_seq_chk #(
  parameter int CLK_STABLE_CYC = 16,
  parameter int MIN_ASSERT_CYC = 16
) (
  input logic clk,
  input logic rst_n,
  input logic pwr_good_i,
  input logic slot_pwr_en_o,
  input logic refclk_en_o,
  input logic perst_n_o,
  input logic link_rdy_o
);
  int unsigned refclk_run;
  int unsigned low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refclk_run <= 0;
      low_run    <= 0;
    end else begin
      refclk_run <= refclk_en_o ? ((refclk_run == 32'hFFFF_FFFF) ? refclk_run : refclk_run + 1) : 0;
      low_run    <= !perst_n_o ? ((low_run == 32'hFFFF_FFFF) ? low_run : low_run + 1) : 0;
    end
  end

  // R10
  perst_needs_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perst_n_o |-> (refclk_en_o && slot_pwr_en_o));

  // R4
  refclk_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perst_n_o) |-> (refclk_run >= CLK_STABLE_CYC));

  // R5
  min_assert_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perst_n_o) |-> (low_run >= MIN_ASSERT_CYC));

  // R8
  link_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_rdy_o) |-> $past(perst_n_o));

  // R6
  fault_drops_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_good_i) |-> (!link_rdy_o && !perst_n_o));

  // R6
  fault_keeps_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(refclk_en_o) && $fell(pwr_good_i)) |=> slot_pwr_en_o);
endmodule

bind pcie_slot_rst_seq pcie_slot_rst_seq_chk #(
  .CLK_STABLE_CYC(CLK_STABLE_CYC),
  .MIN_ASSERT_CYC(MIN_ASSERT_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .pwr_good_i(pwr_good_i),
  .slot_pwr_en_o(slot_pwr_en_o), .refclk_en_o(refclk_en_o),
  .perst_n_o(perst_n_o), .link_rdy_o(link_rdy_o)
);

// File: tb/pcie_slot_rst_seq_tb_top.sv
module pcie_slot_rst_seq_tb_top;
  localparam int PWR = 40;
  localparam int CLKW = 10;
  localparam int MINA = 30;
  localparam bit SKIP = 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic pwr_good_i = 1'b0;
  logic supply_own_i = 1'b0;
  logic slot_pwr_en_o, refclk_en_o, perst_n_o, link_rdy_o;

  int tests = 0;
  int fails = 0;
  int low_run = 0;
  int last_low = 0;

  always #5 clk = ~clk;

  pcie_slot_rst_seq #(
    .PWR_STABLE_CYC(PWR), .CLK_STABLE_CYC(CLKW),
    .MIN_ASSERT_CYC(MINA), .SKIP_PWR_WAIT(SKIP)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pwr_good_i(pwr_good_i),
    .supply_own_i(supply_own_i), .slot_pwr_en_o(slot_pwr_en_o),
    .refclk_en_o(refclk_en_o), .perst_n_o(perst_n_o), .link_rdy_o(link_rdy_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_pwr_delay(input bit own);
    return (own || !SKIP) ? PWR + 1 : 1;
  endfunction

  function automatic int exp_restart_min(input bit own);
    return exp_pwr_delay(own) + CLKW + 1;
  endfunction

  function automatic logic sel(input int which);
    case (which)
      0: return refclk_en_o;
      1: return perst_n_o;
      2: return link_rdy_o;
      default: return slot_pwr_en_o;
    endcase
  endfunction

  // Count negedges until the chosen output reads high.
  task automatic wait_hi(input int which, output int n);
    n = 0;
    while (!sel(which) && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // Background: low-period length of reset, and the R10 / R8 invariants.
  always @(negedge clk) begin
    #1;
    if (!rst_n) low_run = 0;
    else if (!perst_n_o) low_run++;
    else if (low_run != 0) begin
      last_low = low_run;
      low_run = 0;
    end
    if (rst_n && perst_n_o && !(refclk_en_o && slot_pwr_en_o))
      chk(1'b0, "R10 perst high without supply/refclk", 1, 0);
    if (rst_n && link_rdy_o && !perst_n_o)
      chk(1'b0, "R8 link ready while reset low", 1, 0);
  end

  task automatic do_reset(input bit own);
    rst_n = 1'b0;
    start_i = 1'b0;
    supply_own_i = own;
    pwr_good_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    int n2;
    void'($urandom(32'd20190829));

    // Skip path; minimum assertion time sets the release cycle.
    do_reset(1'b0);
    @(negedge clk);
    chk(!slot_pwr_en_o && !refclk_en_o && !perst_n_o && !link_rdy_o,
        "R1 reset state", {slot_pwr_en_o, refclk_en_o, perst_n_o, link_rdy_o}, 0);
    repeat (3) @(negedge clk);
    chk(!slot_pwr_en_o, "R1 idle without start", slot_pwr_en_o, 0);
    pulse_start();
    chk(slot_pwr_en_o, "R1 supply enabled after start", slot_pwr_en_o, 1);
    wait_hi(0, n);
    chk(n == 1, "R3 skipped supply wait", n, 1);
    wait_hi(1, n);
    chk(n >= CLKW + 1, "R4 refclk window lower bound", n, CLKW + 1);
    @(negedge clk); #2;
    chk(last_low >= MINA, "R5 first assertion length", last_low, MINA);

    // Mandatory supply wait; exact window counts.
    do_reset(1'b1);
    @(negedge clk);
    pulse_start();
    wait_hi(0, n);
    chk(n == exp_pwr_delay(1'b1), "R2 supply window", n, exp_pwr_delay(1'b1));
    wait_hi(1, n);
    chk(n == CLKW + 1, "R4 refclk window exact", n, CLKW + 1);
    wait_hi(2, n);
    chk(n == 1, "R8 link one cycle after release", n, 1);

    // Start while released is ignored.
    pulse_start();
    repeat (5) @(negedge clk);
    chk(perst_n_o && link_rdy_o && refclk_en_o && slot_pwr_en_o,
        "R9 start ignored when released", {perst_n_o, link_rdy_o}, 3);

    // Power fault: same-cycle reset, then refclk next edge.
    pwr_good_i = 1'b0;
    #1;
    chk(!perst_n_o, "R6 combinational reset on power loss", perst_n_o, 0);
    chk(!link_rdy_o, "R8 link drops with reset", link_rdy_o, 0);
    @(negedge clk);
    chk(!refclk_en_o && slot_pwr_en_o, "R6 refclk off, supply kept",
        {refclk_en_o, slot_pwr_en_o}, 1);
    repeat (3) @(negedge clk);
    pwr_good_i = 1'b1;
    wait_hi(1, n);
    chk(n >= exp_restart_min(1'b1), "R7 restart through supply wait", n, exp_restart_min(1'b1));
    @(negedge clk); #2;
    chk(last_low >= MINA, "R5 fault assertion length", last_low, MINA);

    // One-cycle glitch inside the supply wait restarts the window.
    do_reset(1'b1);
    @(negedge clk);
    pulse_start();
    repeat (20) @(negedge clk);
    pwr_good_i = 1'b0;
    @(negedge clk);
    chk(!refclk_en_o && !perst_n_o, "R2 no progress while power low", refclk_en_o, 0);
    pwr_good_i = 1'b1;
    wait_hi(0, n);
    chk(n == PWR + 1, "R2 window restarted by glitch", n, PWR + 1);
    wait_hi(1, n);
    chk(n == CLKW + 1, "R4 window after glitch", n, CLKW + 1);

    // Random faults from the released state.
    for (int it = 0; it < 16; it++) begin
      bit own;
      bit quiet;
      int hold;
      own = 1'($urandom % 2);
      hold = 1 + int'($urandom % 60);
      supply_own_i = own;
      repeat (1 + int'($urandom % 20)) @(negedge clk);
      pwr_good_i = 1'b0;
      #1;
      chk(!perst_n_o && !link_rdy_o, "R6 random fault response", {perst_n_o, link_rdy_o}, 0);
      quiet = 1'b1;
      for (int c = 0; c < hold; c++) begin
        start_i = 1'($urandom % 2);
        @(negedge clk);
        if (refclk_en_o || perst_n_o || !slot_pwr_en_o) quiet = 1'b0;
      end
      start_i = 1'b0;
      chk(quiet, "R7 held in fault while power low", quiet, 1);
      pwr_good_i = 1'b1;
      wait_hi(1, n2);
      chk(n2 >= exp_restart_min(own) && n2 <= MINA + exp_restart_min(own) + 3,
          "R7 random restart delay", n2, exp_restart_min(own));
      @(negedge clk); #2;
      chk(last_low >= MINA, "R5 random assertion length", last_low, MINA);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule